// File: doc/BRIEF.md
# BCD to Densely Packed Decimal Word Encoder

This block compresses binary-coded decimal into densely packed decimal. A 64-bit input word carries four groups of three BCD digits, two groups in each 32-bit half. Each 12-bit group is turned into a 10-bit declet by a fixed set of boolean equations. The four declets are placed at fixed offsets inside the matching half of a 64-bit output word, and every other output bit is zero. The block does not check that the digits are legal BCD and does no decimal arithmetic.

Data enters with a valid strobe and leaves one clock later through a single register stage. A two-state controller tracks whether that stage holds a result. ST_EMPTY moves to ST_FULL on an accepted word (transition T_LOAD). ST_FULL stays in ST_FULL when another word arrives (T_STREAM) and falls back to ST_EMPTY when none arrives (T_DRAIN). ST_EMPTY stays where it is while the input is idle (T_IDLE). The output data register keeps its value until a new word is accepted.

Top module: `bcd_declet_packer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. Each accepted word produces exactly one result, in the order the words arrived.
- R3: When every digit of a group is 7 or less, the declet is the three low bits of each digit in order, with a 0 between the second and third digits. For example, group 0x123 gives 0x0A3 and group 0x765 gives 0x3E5.
- R4: For every legal triple of decimal digits (000 to 999), decoding the declet with the standard densely packed decimal decoding gives back the original 12-bit group.
- R5: Group placement is fixed. Input bits [11:0] go to output [9:0], [23:12] to [19:10], [43:32] to [41:32], and [55:44] to [51:42].
- R6: Output bits [31:20] and [63:52] are always 0. Input bits [31:24] and [63:56] do not affect the output.
- R7: Groups whose digits exceed 9 still encode by the same equations, and no error is raised. 0xFFF gives 0x3FF & 0x0FF (equal to the code for 999, that is 0x0FF), and 0xA00 gives 0x00C.
- R8: While `in_valid` is low, `out_data` keeps its previous value.
- R9: Within each declet (bit 9 is the most significant), bit 7 equals input digit-1 bit 0 (group bit 8). Bit 4 equals group bit 4 and bit 0 equals group bit 0. Bit 3 is the OR of the top bits of the three digits (group bits 11, 7 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | 64 | Four BCD groups at [11:0], [23:12], [43:32], [55:44] |
| out_valid | output | 1 | Output word is present this cycle |
| out_data | output | 64 | Four declets at [9:0], [19:10], [41:32], [51:42], other bits 0 |

## Verification
The assertions assume that `in_valid` and `in_data` carry known values whenever reset is released, and that `in_valid` is held low while reset is asserted. They place no limit on digit values, so the pass-through and indicator-bit properties are checked for illegal digits as well. The stimulus follows these assumptions: it changes inputs only on the falling clock edge and holds `in_valid` low during reset. It fills the pad input bits with nonzero patterns so the zero-fill property is tested under unused-bit activity.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
    localparam int DIGIT_W  = 4;
    localparam int DIGITS   = 3;
    localparam int BCD_W    = DIGIT_W * DIGITS;
    localparam int DECLET_W = 10;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;
endpackage

// File: rtl/dpk_declet_enc.sv
module dpk_declet_enc
    import dpk_pkg::*;
(
    input  logic [BCD_W-1:0]    bcd_in,
    output logic [DECLET_W-1:0] declet_out
);
    logic a, b, c, d, e, f, g, h, i, j, k, m;
    logic p, q, r, s, t, u, v, w, x, y;

    always_comb begin
        {a, b, c, d, e, f, g, h, i, j, k, m} = bcd_in;
        // direct copies of the digit low bits
        r = d;
        u = h;
        y = m;
        // indicator bits built from the large-digit flags a, e, i
        v = a | e | i;
        w = a | (e & i) | (~e & ~i & j);
        x = e | (a & i) | (~a & ~i & k);
        // upper fields
        p = (~a & b) | (a & ~i & j) | (a & ~e & i & f);
        q = (~a & c) | (a & ~i & k) | (a & ~e & i & g);
        s = (e & i) | (~e & ~i & f) | (~a & ~e & f) | (~a & e & ~i & j);
        t = (a & i) | (~e & ~i & g) | (~a & ~e & g) | (~a & e & ~i & k);
        declet_out = {p, q, r, s, t, u, v, w, x, y};
    end
endmodule

// File: rtl/dpk_word_map.sv
module dpk_word_map
    import dpk_pkg::*;
#(
    parameter int WORD_W          = 64,
    parameter int GROUPS_PER_HALF = 2
) (
    input  logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] out_word
);
    localparam int HALVES   = 2;
    localparam int HALF_W   = WORD_W / HALVES;
    localparam int N_GROUPS = HALVES * GROUPS_PER_HALF;

    logic [DECLET_W-1:0] declets [N_GROUPS];
    logic                unused_pad;

    assign unused_pad = ^in_word;

    for (genvar hf = 0; hf < HALVES; hf++) begin : g_half
        for (genvar gp = 0; gp < GROUPS_PER_HALF; gp++) begin : g_group
            localparam int IN_LO = hf * HALF_W + gp * BCD_W;
            dpk_declet_enc u_enc (
                .bcd_in     (in_word[IN_LO +: BCD_W]),
                .declet_out (declets[hf * GROUPS_PER_HALF + gp])
            );
        end
    end

    always_comb begin
        out_word = '0;
        for (int n = 0; n < N_GROUPS; n++) begin
            out_word[(n / GROUPS_PER_HALF) * HALF_W + (n % GROUPS_PER_HALF) * DECLET_W +: DECLET_W] = declets[n];
        end
    end
endmodule

// File: rtl/dpk_out_stage.sv
module dpk_out_stage
    import dpk_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] next_word,
    output logic              held_valid,
    output logic [WORD_W-1:0] held_word
);
    stage_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_IDLE, T_LOAD, T_STREAM, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = load ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = load ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_FULL: held_valid = 1'b1;
            default: held_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_word <= '0;
        end else if (load) begin
            held_word <= next_word;
        end
    end
endmodule

// File: rtl/bcd_declet_packer.sv
module bcd_declet_packer
    import dpk_pkg::*;
#(
    parameter int WORD_W          = 64,
    parameter int GROUPS_PER_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    logic [WORD_W-1:0] packed_word;

    dpk_word_map #(
        .WORD_W          (WORD_W),
        .GROUPS_PER_HALF (GROUPS_PER_HALF)
    ) u_map (
        .in_word  (in_data),
        .out_word (packed_word)
    );

    dpk_out_stage #(
        .WORD_W (WORD_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (in_valid),
        .next_word  (packed_word),
        .held_valid (out_valid),
        .held_word  (out_data)
    );
endmodule

// File: rtl/dpk_checker.sv
module dpk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_data,
    input logic        out_valid,
    input logic [63:0] out_data
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_data[31:20] == 12'h000) && (out_data[63:52] == 12'h000)); // R6
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data)); // R8
    AST_COPY_BITS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> (out_data[7] == $past(in_data[8])) && (out_data[4] == $past(in_data[4])) && (out_data[0] == $past(in_data[0]))); // R9
    AST_INDICATOR: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> (out_data[45] == ($past(in_data[55]) | $past(in_data[51]) | $past(in_data[47])))); // R9
endmodule

bind bcd_declet_packer dpk_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/bcd_declet_packer_bench.sv
module bcd_declet_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] din;
        logic [63:0] expv;
        bit          exact;
        int          cyc_in;
    } item_t;

    item_t sb_q[$];

    bcd_declet_packer u_bcd_declet_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // independent decoding of a declet back to three digits
    function automatic logic [11:0] unpack_declet(input logic [9:0] z);
        logic p, q, r, s, t, u, v, w, x, y;
        logic a, b, c, d, e, f, g, h, i, j, k, m;
        {p, q, r, s, t, u, v, w, x, y} = z;
        a = (v & w & ~s) | (v & w & s & t) | (v & w & ~x);
        b = (p & ~v) | (p & ~w) | (p & s & x & ~t);
        c = (q & ~v) | (q & ~w) | (q & s & x & ~t);
        d = r;
        e = (v & x & ~w) | (v & w & x & s) | (v & w & x & ~t);
        f = (s & ~v) | (s & v & ~x) | (p & t & v & w & x & ~s);
        g = (t & ~v) | (t & v & ~x) | (q & t & v & w & x & ~s);
        h = u;
        i = (v & ~w & ~x) | (v & w & x & s) | (v & w & x & t);
        j = (w & ~v) | (s & v & ~w & x) | (p & v & w & ~x) | (p & v & w & ~s & ~t);
        k = (x & ~v) | (t & v & ~w & x) | (q & v & w & ~x) | (q & v & w & ~s & ~t);
        m = y;
        return {a, b, c, d, e, f, g, h, i, j, k, m};
    endfunction

    function automatic logic [11:0] to_bcd(input int n);
        return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic send(input logic [63:0] d, input logic [63:0] e, input bit exact);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        it.din = d; it.expv = e; it.exact = exact; it.cyc_in = cyc;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 64'hDEAD_BEEF_0BAD_F00D;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", 64'(out_valid), 64'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(cyc == it.cyc_in + 1, "R2 latency", 64'(cyc), 64'(it.cyc_in + 1));
                check((out_data[31:20] == 12'h0) && (out_data[63:52] == 12'h0), "R6 pad zero",
                      out_data, out_data & ~64'hFFF0_0000_FFF0_0000);
                if (it.exact) begin
                    check(out_data == it.expv, "R3/R5/R7 exact word", out_data, it.expv);
                end else begin
                    check(unpack_declet(out_data[9:0])   == it.din[11:0],  "R4 R5 group0", 64'(unpack_declet(out_data[9:0])),   64'(it.din[11:0]));
                    check(unpack_declet(out_data[19:10]) == it.din[23:12], "R4 R5 group1", 64'(unpack_declet(out_data[19:10])), 64'(it.din[23:12]));
                    check(unpack_declet(out_data[41:32]) == it.din[43:32], "R4 R5 group2", 64'(unpack_declet(out_data[41:32])), 64'(it.din[43:32]));
                    check(unpack_declet(out_data[51:42]) == it.din[55:44], "R4 R5 group3", 64'(unpack_declet(out_data[51:42])), 64'(it.din[55:44]));
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1 reset state", {out_data[62:0], out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1 after release", {out_data[62:0], out_valid}, 64'd0);

        // R3 small digits, pad input bits noisy (R6)
        send(64'hFF00_0000_FF00_0123, 64'h0000_0000_0000_00A3, 1'b1);
        idle(1);
        send(64'h0000_0000_0000_0765, 64'h0000_0000_0000_03E5, 1'b1);
        // R7 illegal digits
        send(64'h0000_0000_0000_0FFF, 64'h0000_0000_0000_00FF, 1'b1);
        send(64'h0000_0000_0000_0A00, 64'h0000_0000_0000_000C, 1'b1);
        idle(2);
        // R5 placement with distinct groups
        send(64'h00FF_F000_0012_3999,
             64'(10'h0FF) | (64'(10'h0A3) << 10) | (64'(10'h0FF) << 42), 1'b1);
        // R4 all 1000 legal triples, four per word
        for (int n = 0; n < 1000; n += 4) begin
            w = {8'hA5, to_bcd(n + 3), to_bcd(n + 2), 8'h5A, to_bcd(n + 1), to_bcd(n)};
            send(w, '0, 1'b0);
        end
        send(64'h0000_0000_0000_0123, 64'h0000_0000_0000_00A3, 1'b1);
        idle(3);
        // R2 drain and R8 hold
        check(out_valid == 1'b0, "R2 drained", 64'(out_valid), 64'd0);
        check(out_data == 64'h0000_0000_0000_00A3, "R8 hold", out_data, 64'h0000_0000_0000_00A3);
        check(sb_q.size() == 0, "R2 all results seen", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule